// File: doc/BRIEF.md
# Flash Command Sequencer with Status Register

This block is the command front end for an on-chip flash array. Software writes command bytes over a simple bus write port. The block decodes one-cycle commands and two-cycle commands. A two-cycle command is a first byte followed by a confirm or data byte. Once a command is complete, the block launches a job on a program/erase engine through a start pulse that carries an operation code, an address and a data byte. It then waits for the engine's done pulse and folds the fail and over-program flags into an 8-bit status register.

The status register holds four live bits:
- a ready flag,
- an erase-error flag,
- a program-error flag,
- an over-program flag.

The error flags are sticky. While any of them is set, no new program, erase or lock job can be entered until software issues the clear-status byte. A read-select output tells the read path whether to return array data or the status byte. Reads switch to status whenever a job is entered or the status command is written. Writing 0xFF returns reads to the array and abandons a half-entered two-cycle command.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the status byte is 0x80, `rd_status` is 0 (array data selected) and `eng_start` is 0.
- R2: Status bit 7 (ready) is 0 from the cycle `eng_start` is high until the engine's `eng_done` pulse, and returns to 1 on the clock that samples `eng_done`; while busy the status byte reads 0x00 when no error is latched.
- R3: Status bits 6, 2, 1 and 0 always read 0.
- R4: Byte 0x41 followed by any data byte launches one single-cycle `eng_start` with `eng_op` = 0 and with `eng_data`/`eng_addr` taken from the data cycle. On completion the status is 0x80 on success, 0x90 when `eng_fail` is set (bit 4) and 0x88 when `eng_overprog` is set (bit 3).
- R5: First bytes 0x20, 0xA7 and 0x77 followed by 0xD0 launch `eng_op` 1, 2 and 3 respectively, with `eng_addr` from the confirm cycle. A failed erase (op 1 or 2) sets bit 5, and a failed lock program (op 3) sets bit 4.
- R6: A second byte other than 0xD0 or 0xFF after 0x20, 0xA7 or 0x77 sets bits 5 and 4 together, starts no job, and leaves the sequencer idle.
- R7: 0xFF as the second byte of a two-cycle command drops that command with no error and selects array data. In idle, 0xFF also selects array data.
- R8: While any of status bits 5, 4 or 3 is 1, the bytes 0x41, 0x20, 0xA7 and 0x77 are ignored: no job starts and the next byte is decoded as a fresh command.
- R9: Byte 0x50 written while idle clears bits 5, 4 and 3. No other event clears them.
- R10: Byte 0x70, and every accepted program, erase or lock first byte, sets `rd_status` to 1.
- R11: Bus writes arriving while ready is 0 are ignored: they start nothing and change neither `rd_status` nor the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per byte |
| wr_data | input | 8 | Command or data byte |
| wr_addr | input | ADDR_W | Bus address of the write |
| rd_status | output | 1 | Read select: 1 = status byte, 0 = array data |
| status | output | 8 | Status register |
| eng_start | output | 1 | One-cycle job launch pulse |
| eng_op | output | 2 | Job code: 0 program, 1 block erase, 2 erase all, 3 lock program |
| eng_addr | output | ADDR_W | Job address |
| eng_data | output | 8 | Program data byte |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Qualifies `eng_done`: job failed |
| eng_overprog | input | 1 | Qualifies `eng_done`: cells over-programmed |

## Verification
The bench targets these corner cases:
- A 0xD0 arriving in idle must be ignored; a design that treated it as a command would launch a stray job.
- A bad confirm byte must set both error bits; a design that set only one would read 0xA0 or 0x90 instead of 0xB0.
- A blocked first byte must be dropped outright; a design that still latched it would launch a job from the following byte.
- Writes of 0xFF and 0x50 during a running job must be ignored; a design that accepted them would flip the read select or lose an error in flight.
- A failed lock program must land in the program-error bit, not the erase-error bit.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CB_ARRAY     = 8'hFF;
    localparam logic [BYTE_W-1:0] CB_STATUS    = 8'h70;
    localparam logic [BYTE_W-1:0] CB_CLEAR     = 8'h50;
    localparam logic [BYTE_W-1:0] CB_PROG      = 8'h41;
    localparam logic [BYTE_W-1:0] CB_ERASE_BLK = 8'h20;
    localparam logic [BYTE_W-1:0] CB_ERASE_ALL = 8'hA7;
    localparam logic [BYTE_W-1:0] CB_LOCK      = 8'h77;
    localparam logic [BYTE_W-1:0] CB_CONFIRM   = 8'hD0;

    typedef enum logic [1:0] {
        OP_PROG      = 2'd0,
        OP_ERASE_BLK = 2'd1,
        OP_ERASE_ALL = 2'd2,
        OP_LOCK      = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_ARRAY,
        K_STATUS,
        K_CLEAR,
        K_PROG,
        K_TWO,
        K_CONFIRM
    } kind_e;

    typedef struct packed {
        kind_e kind;
        fop_e  op;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CONF,
        ST_BUSY
    } st_e;

    typedef struct packed {
        logic ready;
        logic err_erase;
        logic err_prog;
        logic overprog;
    } stat_t;

    function automatic dec_t decode_byte(input logic [BYTE_W-1:0] b);
        dec_t d;
        d.kind = K_NONE;
        d.op   = OP_PROG;
        case (b)
            CB_ARRAY:     d.kind = K_ARRAY;
            CB_STATUS:    d.kind = K_STATUS;
            CB_CLEAR:     d.kind = K_CLEAR;
            CB_PROG:      d.kind = K_PROG;
            CB_ERASE_BLK: begin d.kind = K_TWO; d.op = OP_ERASE_BLK; end
            CB_ERASE_ALL: begin d.kind = K_TWO; d.op = OP_ERASE_ALL; end
            CB_LOCK:      begin d.kind = K_TWO; d.op = OP_LOCK;      end
            CB_CONFIRM:   d.kind = K_CONFIRM;
            default:      d.kind = K_NONE;
        endcase
        return d;
    endfunction

    function automatic logic is_erase(input fop_e op);
        return (op == OP_ERASE_BLK) || (op == OP_ERASE_ALL);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input stat_t s);
        return {s.ready, 1'b0, s.err_erase, s.err_prog, s.overprog, 3'b000};
    endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output dec_t              dec_out
);
    always_comb begin
        dec_out = decode_byte(byte_in);
    end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              done_ok,
    input  fop_e              job_op,
    input  logic              job_fail,
    input  logic              job_ovp,
    input  logic              seq_err,
    input  logic              clr_req,
    output logic              blocked,
    output logic [BYTE_W-1:0] status_byte
);
    stat_t st_q;

    logic fail_erase;
    logic fail_prog;
    logic ovp_hit;

    always_comb begin
        fail_erase = done_ok && job_fail && is_erase(job_op);
        fail_prog  = done_ok && job_fail && !is_erase(job_op);
        ovp_hit    = done_ok && job_ovp && (job_op == OP_PROG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ready     <= 1'b1;
            st_q.err_erase <= 1'b0;
            st_q.err_prog  <= 1'b0;
            st_q.overprog  <= 1'b0;
        end else begin
            if (launch)
                st_q.ready <= 1'b0;
            else if (done_ok)
                st_q.ready <= 1'b1;

            if (clr_req)
                st_q.err_erase <= 1'b0;
            else if (seq_err || fail_erase)
                st_q.err_erase <= 1'b1;

            if (clr_req)
                st_q.err_prog <= 1'b0;
            else if (seq_err || fail_prog)
                st_q.err_prog <= 1'b1;

            if (clr_req)
                st_q.overprog <= 1'b0;
            else if (ovp_hit)
                st_q.overprog <= 1'b1;
        end
    end

    always_comb begin
        blocked     = st_q.err_erase || st_q.err_prog || st_q.overprog;
        status_byte = pack_status(st_q);
    end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  dec_t              dec,
    input  logic              blocked,
    input  logic              eng_done,
    output logic              launch,
    output logic              clr_req,
    output logic              seq_err,
    output logic              done_ok,
    output logic              rd_status,
    output logic              eng_start,
    output fop_e              eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [BYTE_W-1:0] eng_data
);
    st_e  state_q;
    fop_e pend_op_q;

    logic idle_wr;
    logic data_wr;
    logic conf_wr;
    logic conf_go;
    logic conf_cancel;
    logic accept_prog;
    logic accept_two;

    always_comb begin
        idle_wr     = wr_en && (state_q == ST_IDLE);
        data_wr     = wr_en && (state_q == ST_DATA);
        conf_wr     = wr_en && (state_q == ST_CONF);
        conf_go     = conf_wr && (wr_data == CB_CONFIRM);
        conf_cancel = conf_wr && (wr_data == CB_ARRAY);
        accept_prog = idle_wr && (dec.kind == K_PROG) && !blocked;
        accept_two  = idle_wr && (dec.kind == K_TWO) && !blocked;
        launch      = data_wr || conf_go;
        clr_req     = idle_wr && (dec.kind == K_CLEAR);
        seq_err     = conf_wr && !conf_go && !conf_cancel;
        done_ok     = eng_done && (state_q == ST_BUSY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pend_op_q <= OP_PROG;
            rd_status <= 1'b0;
            eng_start <= 1'b0;
            eng_op    <= OP_PROG;
            eng_addr  <= '0;
            eng_data  <= '0;
        end else begin
            eng_start <= launch;
            if (launch)
                eng_addr <= wr_addr;
            if (data_wr) begin
                eng_op   <= OP_PROG;
                eng_data <= wr_data;
            end
            if (conf_go)
                eng_op <= pend_op_q;

            case (state_q)
                ST_IDLE: begin
                    if (idle_wr) begin
                        if (dec.kind == K_ARRAY)
                            rd_status <= 1'b0;
                        if (dec.kind == K_STATUS)
                            rd_status <= 1'b1;
                        if (accept_prog) begin
                            state_q   <= ST_DATA;
                            rd_status <= 1'b1;
                        end
                        if (accept_two) begin
                            state_q   <= ST_CONF;
                            pend_op_q <= dec.op;
                            rd_status <= 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (data_wr)
                        state_q <= ST_BUSY;
                end
                ST_CONF: begin
                    if (conf_go)
                        state_q <= ST_BUSY;
                    else if (conf_cancel) begin
                        state_q   <= ST_IDLE;
                        rd_status <= 1'b0;
                    end else if (conf_wr)
                        state_q <= ST_IDLE;
                end
                ST_BUSY: begin
                    if (done_ok)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              rd_status,
    output logic [7:0]        status,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [7:0]        eng_data,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              eng_overprog
);
    dec_t dec;
    fop_e op_q;
    logic launch;
    logic clr_req;
    logic seq_err;
    logic done_ok;
    logic blocked;

    fcmd_decode u_dec (
        .byte_in (wr_data),
        .dec_out (dec)
    );

    fcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_addr   (wr_addr),
        .dec       (dec),
        .blocked   (blocked),
        .eng_done  (eng_done),
        .launch    (launch),
        .clr_req   (clr_req),
        .seq_err   (seq_err),
        .done_ok   (done_ok),
        .rd_status (rd_status),
        .eng_start (eng_start),
        .eng_op    (op_q),
        .eng_addr  (eng_addr),
        .eng_data  (eng_data)
    );

    fcmd_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .done_ok     (done_ok),
        .job_op      (op_q),
        .job_fail    (eng_fail),
        .job_ovp     (eng_overprog),
        .seq_err     (seq_err),
        .clr_req     (clr_req),
        .blocked     (blocked),
        .status_byte (status)
    );

    assign eng_op = op_q;
endmodule

// File: rtl/fcmd_ctrl_checker.sv
module fcmd_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] status,
    input logic       eng_start,
    input logic       eng_done
);
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !status[7]); // R2

    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !status[7]) |=> status[7]); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status[6] == 1'b0) && (status[2:0] == 3'b000)); // R3

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start); // R4

    AST_NO_LAUNCH_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (status[5:3] == 3'b000)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !(wr_en && wr_data == 8'h50)) |=> status[5]); // R9

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        !status[7] |=> !eng_start); // R11
endmodule

bind flash_cmd_ctrl fcmd_ctrl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .status    (status),
    .eng_start (eng_start),
    .eng_done  (eng_done)
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = 8'h00;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              rd_status;
    logic [7:0]        status;
    logic              eng_start;
    logic [1:0]        eng_op;
    logic [ADDR_W-1:0] eng_addr;
    logic [7:0]        eng_data;
    logic              eng_done = 1'b0;
    logic              eng_fail = 1'b0;
    logic              eng_overprog = 1'b0;

    int checks = 0;
    int errors = 0;
    int starts = 0;
    int eng_delay = 3;
    logic cfg_fail = 1'b0;
    logic cfg_ovp = 1'b0;
    logic [1:0] last_op = 2'd0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [7:0] last_data = 8'h00;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_flash_cmd_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_addr      (wr_addr),
        .rd_status    (rd_status),
        .status       (status),
        .eng_start    (eng_start),
        .eng_op       (eng_op),
        .eng_addr     (eng_addr),
        .eng_data     (eng_data),
        .eng_done     (eng_done),
        .eng_fail     (eng_fail),
        .eng_overprog (eng_overprog)
    );

    // Engine model: answers every start with one done pulse.
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_fail = 1'b0;
            eng_overprog = 1'b0;
            if (eng_start) begin
                starts++;
                last_op = eng_op;
                last_addr = eng_addr;
                last_data = eng_data;
                repeat (eng_delay - 1) @(negedge clk);
                eng_done = 1'b1;
                eng_fail = cfg_fail;
                eng_overprog = cfg_ovp;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] b, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // {byte, fail, ovp, exp_status, exp_rd, exp_starts} per step
    localparam int NV = 32;
    localparam logic [26:0] VEC [NV] = '{
        {8'h70, 1'b0, 1'b0, 8'h80, 1'b1, 8'd0},  // R10
        {8'hFF, 1'b0, 1'b0, 8'h80, 1'b0, 8'd0},  // R7
        {8'h41, 1'b0, 1'b0, 8'h80, 1'b1, 8'd0},  // R10
        {8'h5A, 1'b0, 1'b0, 8'h80, 1'b1, 8'd1},  // R4 success
        {8'h41, 1'b0, 1'b0, 8'h80, 1'b1, 8'd1},
        {8'h33, 1'b1, 1'b0, 8'h90, 1'b1, 8'd2},  // R4 fail
        {8'h20, 1'b0, 1'b0, 8'h90, 1'b1, 8'd2},  // R8 blocked
        {8'hD0, 1'b0, 1'b0, 8'h90, 1'b1, 8'd2},  // R8 fresh decode
        {8'h50, 1'b0, 1'b0, 8'h80, 1'b1, 8'd2},  // R9
        {8'h41, 1'b0, 1'b0, 8'h80, 1'b1, 8'd2},
        {8'h11, 1'b0, 1'b1, 8'h88, 1'b1, 8'd3},  // R4 overprog
        {8'h50, 1'b0, 1'b0, 8'h80, 1'b1, 8'd3},  // R9
        {8'h20, 1'b0, 1'b0, 8'h80, 1'b1, 8'd3},
        {8'hD0, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},  // R5
        {8'hA7, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},
        {8'h12, 1'b0, 1'b0, 8'hB0, 1'b1, 8'd4},  // R6
        {8'h77, 1'b0, 1'b0, 8'hB0, 1'b1, 8'd4},  // R8
        {8'h50, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},  // R9
        {8'h77, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},
        {8'hFF, 1'b0, 1'b0, 8'h80, 1'b0, 8'd4},  // R7 cancel
        {8'h70, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},
        {8'hA7, 1'b0, 1'b0, 8'h80, 1'b1, 8'd4},
        {8'hD0, 1'b1, 1'b0, 8'hA0, 1'b1, 8'd5},  // R5 erase fail
        {8'h41, 1'b0, 1'b0, 8'hA0, 1'b1, 8'd5},  // R8
        {8'h55, 1'b0, 1'b0, 8'hA0, 1'b1, 8'd5},  // R8 no data cycle
        {8'h50, 1'b0, 1'b0, 8'h80, 1'b1, 8'd5},
        {8'h77, 1'b0, 1'b0, 8'h80, 1'b1, 8'd5},
        {8'hD0, 1'b1, 1'b0, 8'h90, 1'b1, 8'd6},  // R5 lock fail
        {8'h50, 1'b0, 1'b0, 8'h80, 1'b1, 8'd6},
        {8'hFF, 1'b0, 1'b0, 8'h80, 1'b0, 8'd6},
        {8'h20, 1'b0, 1'b0, 8'h80, 1'b1, 8'd6},
        {8'hFF, 1'b0, 1'b0, 8'h80, 1'b0, 8'd6}   // R7 cancel
    };

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "status", status, 8'h80);
        check("R1", "rd_status", rd_status, 0);
        check("R1", "eng_start", eng_start, 0);

        for (int i = 0; i < NV; i++) begin
            cfg_fail = VEC[i][18];
            cfg_ovp  = VEC[i][17];
            bus_write(VEC[i][26:19], ADDR_W'(16'h0100 + i));
            repeat (10) @(negedge clk);
            check("R4-R10 table", "status", status, VEC[i][16:9]);
            check("R4-R10 table", "rd_status", rd_status, VEC[i][8]);
            check("R4-R10 table", "starts", starts, VEC[i][7:0]);
        end
        cfg_fail = 1'b0;
        cfg_ovp = 1'b0;

        // R5: block erase carries confirm-cycle address and op 1
        bus_write(8'h20, 16'h1111);
        bus_write(8'hD0, 16'h4321);
        repeat (10) @(negedge clk);
        check("R5", "op", last_op, 1);
        check("R5", "addr", last_addr, 16'h4321);

        // R5: erase-all op 2
        bus_write(8'hA7, 16'h0000);
        bus_write(8'hD0, 16'h0008);
        repeat (10) @(negedge clk);
        check("R5", "op", last_op, 2);

        // R4: program carries data byte and data-cycle address
        bus_write(8'h41, 16'h0001);
        bus_write(8'hC3, 16'h0ABC);
        repeat (10) @(negedge clk);
        check("R4", "op", last_op, 0);
        check("R4", "data", last_data, 8'hC3);
        check("R4", "addr", last_addr, 16'h0ABC);

        // R2, R11: long job, writes during busy are ignored
        eng_delay = 20;
        base = starts;
        bus_write(8'h41, 16'h0002);
        bus_write(8'h7E, 16'h0003);
        @(negedge clk);
        check("R2", "busy status", status, 8'h00);
        bus_write(8'hFF, 16'h0004);
        check("R11", "rd_status after FF while busy", rd_status, 1);
        bus_write(8'h20, 16'h0005);
        bus_write(8'hD0, 16'h0006);
        check("R11", "still busy", status, 8'h00);
        repeat (30) @(negedge clk);
        check("R2", "ready after done", status, 8'h80);
        check("R11", "starts", starts, base + 1);
        check("R11", "rd_status", rd_status, 1);

        // R11: error flag raised in flight survives a busy clear write
        cfg_fail = 1'b1;
        bus_write(8'h20, 16'h0007);
        bus_write(8'hD0, 16'h0008);
        bus_write(8'h50, 16'h0009);
        repeat (30) @(negedge clk);
        check("R11", "clear while busy ignored", status, 8'hA0);
        cfg_fail = 1'b0;
        eng_delay = 3;

        // R6: bad confirm with no prior error, and no start
        bus_write(8'h50, 16'h0000);
        base = starts;
        bus_write(8'h20, 16'h0000);
        bus_write(8'h00, 16'h0000);
        repeat (10) @(negedge clk);
        check("R6", "status", status, 8'hB0);
        check("R6", "starts", starts, base);

        // R1: reset mid-error restores power-up state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "status after reset", status, 8'h80);
        check("R1", "rd_status after reset", rd_status, 0);

        finished = 1'b1;
    end

    initial begin
        fork
            begin
                wait (finished);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule